// File: doc/BRIEF.md
# Fixed-Key Pipelined Table Multiplier for Zero-Knowledge Prover Response

This block forms the prover's response `y = r + c * K` for an identification exchange in which the secret `K` never changes after the chip is built. `K` is an elaboration-time parameter and there is no key port. The challenge `c` is split into 4-bit digits. Each digit selects one entry from its own small table, and every table holds the sixteen multiples `0*K .. 15*K`. The looked-up partial products are shifted into place by wiring alone. A balanced adder tree sums them, with one register stage per tree level, and a last stage adds the commitment `r`.

A caller presents a challenge and a commitment together with `in_valid`. The block accepts a new pair on every clock. Each result comes out with `out_valid` after a fixed number of cycles, in the order the inputs went in. With the default widths (128-bit key, 32-bit challenge, 240-bit commitment), the tree has three levels and the result is 241 bits wide.

Top module: `kcm_prover_core`

## Requirements
- R1: When `out_valid` is high, `out_y` equals `in_commit + in_chal * KEY` for the matching input, computed without truncation in R_W+1 bits. The carry out of the commitment width appears in bit R_W.
- R2: Challenge digit i is `in_chal[4i+3:4i]` and carries weight 16^i in the product. A challenge whose only nonzero digit is d at position i yields `r + d * 16^i * KEY`.
- R3: An input accepted at rising edge n (with `in_valid` high and `rst_n` high) produces `out_valid` high from edge n+LAT-1 until edge n+LAT. LAT = $clog2(CH_W/4) + 2, which is 5 with the defaults. At no other time does `out_valid` rise.
- R4: Inputs presented on consecutive cycles produce results on consecutive cycles, in input order, with no bubble.
- R5: While `rst_n` is low (synchronous, active low), the edge clears `out_valid` and `out_y` to 0. Inputs sampled during reset, and inputs still in flight when reset is asserted, never produce an output.
- R6: While `out_valid` is low, `out_y` keeps the last result (or 0 since reset).
- R7: Extreme operands give exact results. A zero challenge yields `r`. An all-ones challenge with an all-ones commitment sets the carry bit R_W.
- R8: Challenge and commitment values presented with `in_valid` low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Challenge and commitment are valid this cycle |
| in_chal | input | CH_W (32) | Challenge value |
| in_commit | input | R_W (240) | Commitment value r |
| out_valid | output | 1 | Result valid this cycle |
| out_y | output | R_W+1 (241) | Response r + c*K |

## Verification
Single-digit challenges are walked across every digit position. A table wired to the wrong weight or a misplaced shift then gives a product off by a power of 16. Long back-to-back bursts expose a stage that drops or duplicates a result, and sparse traffic with changing data on idle cycles exposes an output register that loads when it should hold. All-ones operands reveal a dropped top carry. A reset asserted with results still in flight catches a valid pipeline that leaks stale results after reset.

// File: rtl/kcm_pkg.sv
package kcm_pkg;

  // Number of challenge digits for a given challenge width and digit width.
  function automatic int unsigned digit_count(input int unsigned ch_w, input int unsigned dg_w);
    return (ch_w + dg_w - 1) / dg_w;
  endfunction

  // Cycles from input sampling edge to valid result (inclusive count of registers).
  function automatic int unsigned pipe_latency(input int unsigned ndig);
    return $clog2(ndig) + 2;
  endfunction

endpackage

// File: rtl/kcm_digit_rom.sv
module kcm_digit_rom #(
  parameter int unsigned KEY_W = 128,
  parameter int unsigned DIG_W = 4,
  parameter logic [KEY_W-1:0] KEY = '0,
  localparam int unsigned TW = KEY_W + DIG_W,
  localparam int unsigned NE = 1 << DIG_W
) (
  input  logic             clk,
  input  logic [DIG_W-1:0] digit,
  output logic [TW-1:0]    part_q
);

  // Multiple k*KEY by shift-and-add, evaluated at elaboration.
  function automatic logic [TW-1:0] key_multiple(input int unsigned k);
    logic [TW-1:0] acc;
    acc = '0;
    for (int b = 0; b < int'(DIG_W); b++) begin
      if (k[b]) acc = acc + (TW'(KEY) << b);
    end
    return acc;
  endfunction

  logic [TW-1:0] rom [NE];

  for (genvar k = 0; k < NE; k++) begin : g_entry
    assign rom[k] = key_multiple(k);
  end

  always_ff @(posedge clk) begin
    part_q <= rom[digit];
  end

endmodule

// File: rtl/kcm_sum_tree.sv
module kcm_sum_tree #(
  parameter int unsigned NLEAF = 8,
  parameter int unsigned W = 160,
  localparam int unsigned LVL = $clog2(NLEAF),
  localparam int unsigned NPAD = 1 << LVL
) (
  input  logic              clk,
  input  logic [NLEAF*W-1:0] leaves,
  output logic [W-1:0]      root
);

  // Heap layout: inner nodes 0..NPAD-2 are registers, leaves follow.
  logic [W-1:0] inner_q [NPAD-1];
  logic [W-1:0] node    [2*NPAD-1];

  always_comb begin
    for (int j = 0; j < int'(NPAD) - 1; j++) node[j] = inner_q[j];
    for (int j = 0; j < int'(NPAD); j++) begin
      node[int'(NPAD) - 1 + j] = (j < int'(NLEAF)) ? leaves[j*W +: W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(NPAD) - 1; i++) begin
      inner_q[i] <= node[2*i+1] + node[2*i+2];
    end
  end

  assign root = inner_q[0];

endmodule

// File: rtl/kcm_pipe_delay.sv
module kcm_pipe_delay #(
  parameter int unsigned W = 1,
  parameter int unsigned DEPTH = 1,
  parameter bit CLEAR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [DEPTH];

  if (CLEAR) begin : g_clr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < int'(DEPTH); i++) stage[i] <= '0;
      end else begin
        stage[0] <= din;
        for (int i = 1; i < int'(DEPTH); i++) stage[i] <= stage[i-1];
      end
    end
  end else begin : g_noclr
    logic unused_rst;
    assign unused_rst = rst_n;
    always_ff @(posedge clk) begin
      stage[0] <= din;
      for (int i = 1; i < int'(DEPTH); i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/kcm_prover_core.sv
module kcm_prover_core
  import kcm_pkg::*;
#(
  parameter int unsigned KEY_W = 128,
  parameter int unsigned CH_W  = 32,
  parameter int unsigned DIG_W = 4,
  parameter int unsigned R_W   = KEY_W + CH_W + 80,
  parameter logic [KEY_W-1:0] KEY = 128'hC3A5_9E17_4B2D_F081_6E3C_A95B_12D7_48F9,
  localparam int unsigned NDIG   = digit_count(CH_W, DIG_W),
  localparam int unsigned TW     = KEY_W + DIG_W,
  localparam int unsigned PROD_W = CH_W + KEY_W,
  localparam int unsigned TREE_LVL = $clog2(NDIG),
  localparam int unsigned Y_W    = R_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CH_W-1:0] in_chal,
  input  logic [R_W-1:0]  in_commit,
  output logic            out_valid,
  output logic [Y_W-1:0]  out_y
);

  logic [TW-1:0]          part [NDIG];
  logic [NDIG*PROD_W-1:0] leaves;
  logic [PROD_W-1:0]      prod_value;
  logic                   prod_valid;
  logic [R_W-1:0]         commit_aligned;

  // One table per digit; alignment by digit position is pure wiring.
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    kcm_digit_rom #(.KEY_W(KEY_W), .DIG_W(DIG_W), .KEY(KEY)) rom_i (
      .clk    (clk),
      .digit  (in_chal[i*DIG_W +: DIG_W]),
      .part_q (part[i])
    );
    assign leaves[i*PROD_W +: PROD_W] = PROD_W'(part[i]) << (i*DIG_W);
  end

  kcm_sum_tree #(.NLEAF(NDIG), .W(PROD_W)) tree_i (
    .clk    (clk),
    .leaves (leaves),
    .root   (prod_value)
  );

  // Valid and commitment travel alongside the table and tree stages.
  kcm_pipe_delay #(.W(1), .DEPTH(TREE_LVL + 1), .CLEAR(1'b1)) vdly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (in_valid),
    .dout  (prod_valid)
  );

  kcm_pipe_delay #(.W(R_W), .DEPTH(TREE_LVL + 1), .CLEAR(1'b0)) rdly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (in_commit),
    .dout  (commit_aligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= prod_valid;
      if (prod_valid) out_y <= Y_W'(commit_aligned) + Y_W'(prod_value);
    end
  end

endmodule

// File: rtl/kcm_prover_core_chk.sv
module kcm_prover_core_chk #(
  parameter int unsigned KEY_W = 128,
  parameter int unsigned CH_W  = 32,
  parameter int unsigned DIG_W = 4,
  parameter int unsigned R_W   = 240,
  parameter logic [KEY_W-1:0] KEY = '0,
  localparam int unsigned Y_W = R_W + 1,
  localparam int unsigned LAT = $clog2((CH_W + DIG_W - 1) / DIG_W) + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [CH_W-1:0] in_chal,
  input logic [R_W-1:0]  in_commit,
  input logic            out_valid,
  input logic [Y_W-1:0]  out_y,
  input logic            prod_valid
);

  logic           sh_v [LAT];
  logic [Y_W-1:0] sh_y [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(LAT); i++) sh_v[i] <= 1'b0;
    end else begin
      sh_v[0] <= in_valid;
      for (int i = 1; i < int'(LAT); i++) sh_v[i] <= sh_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    sh_y[0] <= Y_W'(in_commit) + Y_W'(in_chal) * Y_W'(KEY);
    for (int i = 1; i < int'(LAT); i++) sh_y[i] <= sh_y[i-1];
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh_v[LAT-1]);

  a_r1_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_y == sh_y[LAT-1]));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_y));

  a_r5_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_y == '0));

  a_r3_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid |=> out_valid);

endmodule

bind kcm_prover_core kcm_prover_core_chk #(
  .KEY_W(KEY_W), .CH_W(CH_W), .DIG_W(DIG_W), .R_W(R_W), .KEY(KEY)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_chal    (in_chal),
  .in_commit  (in_commit),
  .out_valid  (out_valid),
  .out_y      (out_y),
  .prod_valid (prod_valid)
);

// File: tb/kcm_prover_core_tb.sv
module kcm_prover_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int KEY_W = 128;
  localparam int CH_W  = 32;
  localparam int R_W   = 240;
  localparam int Y_W   = R_W + 1;
  localparam int LAT   = 5;
  localparam logic [KEY_W-1:0] TB_KEY = 128'hF1E2_D3C4_B5A6_9788_0123_4567_89AB_CDEF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [CH_W-1:0] in_chal = '0;
  logic [R_W-1:0]  in_commit = '0;
  logic            out_valid;
  logic [Y_W-1:0]  out_y;

  kcm_prover_core #(.KEY_W(KEY_W), .CH_W(CH_W), .DIG_W(4), .R_W(R_W), .KEY(TB_KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chal(in_chal),
    .in_commit(in_commit), .out_valid(out_valid), .out_y(out_y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  bit check_en = 1'b0;
  string phase = "R5";

  typedef struct packed { int unsigned due; logic [Y_W-1:0] y; } exp_t;
  exp_t exp_q[$];
  logic [Y_W-1:0] last_y = '0;

  task automatic check(input bit ok, input string tag, input logic [Y_W-1:0] act, input logic [Y_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s phase=%s cyc=%0d actual=%h expected=%h", tag, phase, cyc, act, exp);
    end
  endtask

  // Reference model: big-integer arithmetic on each accepted input.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      exp_q.delete();
      last_y <= '0;
    end else if (in_valid) begin
      exp_q.push_back('{due: cyc + 1 + LAT - 1,
                        y: Y_W'(in_commit) + Y_W'(in_chal) * Y_W'(TB_KEY)});
    end
  end

  always @(negedge clk) begin
    if (check_en) begin
      bit expv;
      expv = (exp_q.size() > 0) && (exp_q[0].due == cyc);
      check(out_valid == expv, "R3", Y_W'(out_valid), Y_W'(expv));
      if (expv) begin
        check(out_y == exp_q[0].y, "R1", out_y, exp_q[0].y);
        last_y = exp_q[0].y;
        void'(exp_q.pop_front());
      end else begin
        check(out_y == last_y, "R6", out_y, last_y);
      end
    end
  end

  function automatic logic [R_W-1:0] rand_r();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v[R_W-1:0];
  endfunction

  task automatic send(input bit v, input logic [CH_W-1:0] c, input logic [R_W-1:0] r);
    @(negedge clk);
    in_valid  = v;
    in_chal   = c;
    in_commit = r;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) send(1'b0, $urandom, rand_r());
  endtask

  initial begin
    // R5: reset with valid traffic presented; nothing may come out.
    for (int k = 0; k < 6; k++) begin
      send(1'b1, $urandom, rand_r());
      if (k > 0) begin
        check(out_valid == 1'b0, "R5", Y_W'(out_valid), '0);
        check(out_y == '0, "R5", out_y, '0);
      end
    end
    send(1'b0, '0, '0);
    rst_n = 1'b1;
    check_en = 1'b1;
    idle(3);

    // R2: one nonzero digit at each position.
    phase = "R2";
    for (int i = 0; i < 8; i++) send(1'b1, CH_W'(32'h9) << (4*i), '0);
    for (int i = 0; i < 8; i++) send(1'b1, CH_W'(32'hF) << (4*i), R_W'(i));
    idle(LAT + 2);

    // R4: back-to-back burst.
    phase = "R4";
    for (int k = 0; k < 40; k++) send(1'b1, $urandom, rand_r());
    idle(LAT + 2);

    // R8: sparse traffic with changing data on idle cycles.
    phase = "R8";
    for (int k = 0; k < 30; k++) send(k % 3 == 0, $urandom, rand_r());
    idle(LAT + 4);
    check(out_valid == 1'b0, "R8", Y_W'(out_valid), '0);

    // R7: extreme operands.
    phase = "R7";
    send(1'b1, '0, rand_r());
    send(1'b1, '1, '1);
    send(1'b1, '1, '0);
    send(1'b1, '0, '0);
    idle(LAT + 2);

    // R5: reset with results still in flight.
    phase = "R5";
    send(1'b1, $urandom, rand_r());
    send(1'b1, $urandom, rand_r());
    send(1'b1, $urandom, rand_r());
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(LAT + 3);
    check(out_valid == 1'b0, "R5", Y_W'(out_valid), '0);
    check(out_y == '0, "R5", out_y, '0);

    // Final sanity after reset recovery.
    phase = "R1";
    for (int k = 0; k < 10; k++) send(1'b1, $urandom, rand_r());
    idle(LAT + 2);
    check(exp_q.size() == 0, "R1", Y_W'(exp_q.size()), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule